// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the timing strobes of an 8051-style external memory bus from the oscillator clock. It splits every machine cycle into twelve oscillator phases. From the phase it drives three outputs: an address-latch pulse, a program-store read strobe, and a select line. The select line tells the upper address port whether to drive the high address byte or its own port latch. A CPU core supplies the program counter, the external-access pin level and a per-cycle request for an external data access, flagged as 8-bit or 16-bit addressed. The sequencer decides whether each cycle is an internal fetch, an external fetch or a data cycle, and it shapes the strobes to match.

The block also qualifies the reset pin for the core. A high level on that pin counts only once it has been held for two full machine cycles. The oscillator-domain logic itself is cleared by a synchronous active-low reset.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: A machine cycle spans 12 clocks. `rst_n` low clears the phase counter to 0. The first clock edge with `rst_n` high starts the sequencer, and the following clock shows phase 0.
- R2: In a cycle that is not a data cycle, `ale_o` is high during phases 0, 1, 6 and 7. This gives two 2-clock pulses per machine cycle, one pulse per 6 oscillator periods.
- R3: In a data cycle, the `ale_o` pulse at phases 6 and 7 is left out. Only the phase 0 and 1 pulse remains.
- R4: In an external fetch cycle, `pgm_rd_o` is high during phases 3 to 5 and phases 9 to 11. That is two activations per machine cycle, and `pgm_rd_o` is never high while `ale_o` is high.
- R5: In a data cycle, both `pgm_rd_o` activations are left out.
- R6: In an internal fetch cycle, `pgm_rd_o` stays low for the whole cycle.
- R7: With `ext_access_i` low, every fetch is external, including program counter values 0x0000 to 0x0FFF.
- R8: With `ext_access_i` high, a fetch is internal when `pc_i` is at most 0x0FFF and external when `pc_i` is 0x1000 or above.
- R9: `hi_sel_o` is 1 (high address byte) in external fetch cycles and in data cycles with `xdata_wide_i` = 1. It is 0 (port latch) in internal fetch cycles and in data cycles with `xdata_wide_i` = 0.
- R10: The inputs `ext_access_i`, `pc_i`, `xdata_req_i` and `xdata_wide_i` are sampled at the clock edge that ends phase 11, and at the starting edge. The sampled values set the type of the whole next machine cycle.
- R11: `core_rst_o` goes high only after `rst_pin_i` has been sampled high on 24 consecutive clock edges. It goes low at the first edge that samples the pin low.
- R12: While `rst_n` is low, `ale_o`, `pgm_rd_o`, `hi_sel_o` and `core_rst_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_pin_i | input | 1 | Raw reset pin level, active high |
| ext_access_i | input | 1 | External-access pin level; low forces external fetch |
| pc_i | input | 16 | Current program counter |
| xdata_req_i | input | 1 | Next machine cycle is an external data access |
| xdata_wide_i | input | 1 | Data access uses a 16-bit address |
| ale_o | output | 1 | Address-latch pulse |
| pgm_rd_o | output | 1 | Program-store read strobe, active high |
| hi_sel_o | output | 1 | Upper port source: 1 high address byte, 0 port latch |
| core_rst_o | output | 1 | Qualified reset to the core |

## Verification
Each machine cycle is scored by counting the rising edges of the address-latch pulse and the read strobe, and by sampling the select line mid-cycle. The bench runs three patterns. Internal fetches at 0x0000 and 0x0FFF check that the read strobe stays silent. External fetches, reached through a low access pin, through 0x1000 and through 0xFFFF, check the two-strobe shape and the threshold edge. A mixed stream places wide and narrow data cycles between fetches, which shows the one missing latch pulse, the two missing read strobes, and the select source in each kind of data cycle. The reset pin is held for one edge short of the qualifying span and then for the full span, which separates an off-by-one in the qualifier from correct behaviour.

// File: rtl/ebs_pkg.sv
// Shared types of the external bus strobe sequencer.
// Assumes: one cycle descriptor is latched per machine cycle.
package ebs_pkg;

    // Kind of the current machine cycle, as latched at its start
    typedef struct packed {
        logic ext_fetch;   // code comes from the external program store
        logic data;        // cycle is an external data access
        logic wide;        // data access carries a 16-bit address
    } cyc_t;

endpackage

// File: rtl/ebs_phase_ctr.sv
// Oscillator phase counter of the machine cycle.
// Assumes: PHASES >= 2. After reset, the first edge only sets run_o, so
// phase 0 is shown for a full clock once the sequencer is live.
module ebs_phase_ctr #(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          run_o,
    output logic [PW-1:0] phase_o
);

    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    // Mark the sequencer as live one edge after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) run_o <= 1'b0;
        else        run_o <= 1'b1;
    end

    // Step the phase and wrap at the end of the machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)              phase_o <= '0;
        else if (!run_o)         phase_o <= '0;
        else if (phase_o == LAST) phase_o <= '0;
        else                     phase_o <= phase_o + 1'b1;
    end

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && phase_o == LAST) |=> (phase_o == '0)); // R1

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o <= LAST); // R1

endmodule

// File: rtl/ebs_cycle_sel.sv
// Decides the kind of the next machine cycle and holds it for the whole cycle.
// Assumes: load_i is high on the edge that starts a machine cycle.
module ebs_cycle_sel
    import ebs_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [15:0] INT_LIMIT = 16'h0FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          ext_access_i,
    input  logic [AW-1:0] pc_i,
    input  logic          xreq_i,
    input  logic          xwide_i,
    output cyc_t          cyc_o
);

    localparam logic [AW-1:0] LIMIT = AW'(INT_LIMIT);

    logic beyond_int;
    cyc_t nxt;

    // Fetch goes outside when the pin forbids internal code or PC is past it
    always_comb begin
        beyond_int    = (pc_i > LIMIT);
        nxt.ext_fetch = !ext_access_i || beyond_int;
        nxt.data      = xreq_i;
        nxt.wide      = xreq_i && xwide_i;
    end

    // Latch the descriptor at the start of each machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      cyc_o <= '0;
        else if (load_i) cyc_o <= nxt;
    end

    AST_LOW_PIN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !ext_access_i) |=> cyc_o.ext_fetch); // R7

    AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cyc_o)); // R10

endmodule

// File: rtl/ebs_strobe_gen.sv
// Decodes phase and cycle kind into the bus strobes.
// Assumes: PHASES is even and at least 8, so each half cycle has room for a
// 2-phase latch pulse, a one-phase gap and the read window.
module ebs_strobe_gen
    import ebs_pkg::*;
#(
    parameter int PHASES   = 12,
    parameter int ALE_W    = 2,
    parameter int RD_START = 3,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          run_i,
    input  logic [PW-1:0] phase_i,
    input  cyc_t          cyc_i,
    output logic          ale_o,
    output logic          pgm_rd_o,
    output logic          hi_sel_o
);

    localparam int HALF = PHASES / 2;
    localparam logic [PW-1:0] P_HALF = PW'(HALF);
    localparam logic [PW-1:0] P_ALEW = PW'(ALE_W);
    localparam logic [PW-1:0] P_RD   = PW'(RD_START);

    logic          second_half;
    logic [PW-1:0] sub_phase;
    logic          ale_slot;
    logic          rd_slot;

    // Fold both halves of the cycle onto one half-cycle position
    always_comb begin
        second_half = (phase_i >= P_HALF);
        sub_phase   = second_half ? (phase_i - P_HALF) : phase_i;
        ale_slot    = (sub_phase < P_ALEW);
        rd_slot     = (sub_phase >= P_RD);
    end

    // Gate slots by cycle kind: data cycles drop the late latch and all reads
    always_comb begin
        ale_o    = run_i && ale_slot && !(cyc_i.data && second_half);
        pgm_rd_o = run_i && rd_slot && cyc_i.ext_fetch && !cyc_i.data;
        hi_sel_o = run_i && (cyc_i.data ? cyc_i.wide : cyc_i.ext_fetch);
    end

endmodule

// File: rtl/ebs_reset_qual.sv
// Qualifies the raw reset pin: it must stay high for HOLD consecutive edges.
// Assumes: the pin is already synchronous to clk.
module ebs_reset_qual #(
    parameter int HOLD = 24,
    localparam int CW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic core_rst_o
);

    localparam logic [CW-1:0] FULL = CW'(HOLD);

    logic [CW-1:0] held;

    // Count consecutive high samples, saturating at the qualifying span
    always_ff @(posedge clk) begin
        if (!rst_n)          held <= '0;
        else if (!pin_i)     held <= '0;
        else if (held != FULL) held <= held + 1'b1;
    end

    // Raise the core reset once the span is complete
    always_comb core_rst_o = (held == FULL);

    AST_QUAL_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_o) |-> $past(pin_i)); // R11

    AST_QUAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_i |=> !core_rst_o); // R11

endmodule

// File: rtl/ext_bus_strobe_seq.sv
// Top of the external bus strobe sequencer: phase counter, cycle selector,
// strobe decoder and reset-pin qualifier.
// Assumes: clk is the oscillator; cycle inputs are stable at the edge that
// closes each machine cycle.
module ext_bus_strobe_seq
    import ebs_pkg::*;
#(
    parameter int          PHASES    = 12,
    parameter int          AW        = 16,
    parameter logic [15:0] INT_LIMIT = 16'h0FFF,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_pin_i,
    input  logic          ext_access_i,
    input  logic [AW-1:0] pc_i,
    input  logic          xdata_req_i,
    input  logic          xdata_wide_i,
    output logic          ale_o,
    output logic          pgm_rd_o,
    output logic          hi_sel_o,
    output logic          core_rst_o
);

    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic          run;
    logic [PW-1:0] phase;
    logic          load;
    cyc_t          cyc;

    ebs_phase_ctr #(.PHASES(PHASES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_o   (run),
        .phase_o (phase)
    );

    // Start a new cycle descriptor at go-live and at every cycle boundary
    always_comb load = !run || (phase == LAST);

    ebs_cycle_sel #(.AW(AW), .INT_LIMIT(INT_LIMIT)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .ext_access_i (ext_access_i),
        .pc_i         (pc_i),
        .xreq_i       (xdata_req_i),
        .xwide_i      (xdata_wide_i),
        .cyc_o        (cyc)
    );

    ebs_strobe_gen #(.PHASES(PHASES)) u_strobe (
        .run_i    (run),
        .phase_i  (phase),
        .cyc_i    (cyc),
        .ale_o    (ale_o),
        .pgm_rd_o (pgm_rd_o),
        .hi_sel_o (hi_sel_o)
    );

    ebs_reset_qual #(.HOLD(2 * PHASES)) u_rq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (rst_pin_i),
        .core_rst_o (core_rst_o)
    );

    AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale_o) |=> ale_o); // R2

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale_o && pgm_rd_o)); // R4

    AST_DATA_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cyc.data |-> !pgm_rd_o); // R5

    AST_INT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc.ext_fetch |-> !pgm_rd_o); // R6

    AST_IDLE_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !run); // R12

endmodule

// File: tb/test_ext_bus_strobe_seq.sv
// Scoreboard bench: the driver pushes one expected cycle profile per machine
// cycle; the monitor counts strobe edges over each cycle and compares.
module test_ext_bus_strobe_seq;

    typedef struct {
        int    ale_n;
        int    rd_n;
        logic  hs;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_pin = 1'b0;
    logic        ea = 1'b1;
    logic [15:0] pc = 16'h0000;
    logic        xreq = 1'b0;
    logic        xwide = 1'b0;
    logic        ale, rd, hs, crst;

    int   total = 0;
    int   bad = 0;
    exp_t exp_q[$];
    bit   tracking = 1'b0;
    int   nidx = 0;
    int   cnt_a = 0;
    int   cnt_r = 0;
    logic hs_mid = 1'b0;
    logic ale_prev = 1'b0;
    logic rd_prev = 1'b0;
    event ev_mid;

    always #4 clk = ~clk;

    ext_bus_strobe_seq i_ext_bus_strobe_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_pin_i    (rst_pin),
        .ext_access_i (ea),
        .pc_i         (pc),
        .xdata_req_i  (xreq),
        .xdata_wide_i (xwide),
        .ale_o        (ale),
        .pgm_rd_o     (rd),
        .hi_sel_o     (hs),
        .core_rst_o   (crst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic a, input logic [15:0] p,
                                   input logic xr, input logic xw);
        exp_t e;
        logic ext;
        ext = !a || (p > 16'h0FFF);
        if (xr) begin
            e.ale_n = 1; e.rd_n = 0; e.hs = xw;
            e.tag = xw ? "R3 R5 R9 wide data" : "R3 R5 R9 narrow data";
        end else begin
            e.ale_n = 2; e.rd_n = ext ? 2 : 0; e.hs = ext;
            e.tag = ext ? "R2 R4 R7 R8 R9 R10 ext fetch" : "R2 R6 R8 R9 R10 int fetch";
        end
        return e;
    endfunction

    // Set the inputs for the next machine cycle and queue its expected profile
    task automatic drive(input logic a, input logic [15:0] p,
                         input logic xr, input logic xw);
        @(ev_mid);
        ea = a; pc = p; xreq = xr; xwide = xw;
        exp_q.push_back(model(a, p, xr, xw));
    endtask

    // Monitor: count strobe rises per machine cycle and score at its end
    always @(negedge clk) begin
        if (tracking) begin
            int ph;
            ph = nidx % 12;
            if (nidx == 0) chk(ale === 1'b1, "R1 phase0 latch pulse", ale, 1);
            if (nidx == 2) chk(ale === 1'b0, "R1 phase2 latch low", ale, 0);
            if (ale && !ale_prev) cnt_a++;
            if (rd && !rd_prev) cnt_r++;
            if (ph == 4) hs_mid = hs;
            if (ph == 5) -> ev_mid;
            if (ph == 11) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 scoreboard underrun", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cnt_a == e.ale_n, {e.tag, " latch count"}, cnt_a, e.ale_n);
                    chk(cnt_r == e.rd_n, {e.tag, " read count"}, cnt_r, e.rd_n);
                    chk(hs_mid === e.hs, {e.tag, " select"}, int'(hs_mid), int'(e.hs));
                end
                cnt_a = 0;
                cnt_r = 0;
            end
            ale_prev = ale;
            rd_prev  = rd;
            nidx++;
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(ale === 1'b0, "R12 latch in reset", ale, 0);
        chk(rd === 1'b0, "R12 read in reset", rd, 0);
        chk(hs === 1'b0, "R12 select in reset", hs, 0);
        chk(crst === 1'b0, "R12 core reset in reset", crst, 0);
        exp_q.push_back(model(1'b1, 16'h0000, 1'b0, 1'b0));
        rst_n = 1'b1;
        @(posedge clk);
        #1 tracking = 1'b1;

        // internal fetches, including the last internal address
        drive(1'b1, 16'h0000, 1'b0, 1'b0);
        drive(1'b1, 16'h0FFF, 1'b0, 1'b0);
        // external fetches: low pin, threshold crossing, top of space
        drive(1'b0, 16'h0000, 1'b0, 1'b0);
        drive(1'b0, 16'h0FFF, 1'b0, 1'b0);
        drive(1'b1, 16'h1000, 1'b0, 1'b0);
        drive(1'b1, 16'hFFFF, 1'b0, 1'b0);
        // mixed stream with data cycles
        drive(1'b1, 16'h2000, 1'b1, 1'b1);
        drive(1'b1, 16'h2001, 1'b0, 1'b0);
        drive(1'b1, 16'h0100, 1'b1, 1'b0);
        drive(1'b1, 16'h0101, 1'b0, 1'b0);
        drive(1'b0, 16'h0040, 1'b1, 1'b0);
        drive(1'b0, 16'h0041, 1'b1, 1'b1);
        drive(1'b1, 16'h0042, 1'b0, 1'b0);
        wait (exp_q.size() == 0);
        @(negedge clk);
        tracking = 1'b0;

        // reset pin held one edge short of the span
        @(negedge clk) rst_pin = 1'b1;
        repeat (23) @(posedge clk);
        @(negedge clk);
        chk(crst === 1'b0, "R11 23 edges not enough", crst, 0);
        @(negedge clk);
        chk(crst === 1'b1, "R11 24 edges qualify", crst, 1);
        rst_pin = 1'b0;
        @(negedge clk);
        chk(crst === 1'b0, "R11 release on low pin", crst, 0);
        // a short glitch restarts the count
        rst_pin = 1'b1;
        repeat (20) @(negedge clk);
        rst_pin = 1'b0;
        @(negedge clk) rst_pin = 1'b1;
        repeat (10) @(negedge clk);
        chk(crst === 1'b0, "R11 count restarts after low", crst, 0);
        rst_pin = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule